// File: doc/BRIEF.md
# Vector-Extension Prefix Decoder

This block sits in an instruction fetch path and reads instruction bytes one per accepted transfer. When the first byte opens a two-byte (0xC5) or three-byte (0xC4) vector-extension prefix, it collects the remaining prefix bytes. It then presents the decoded fields together with a one-cycle done strobe: register-extension bits, operand-width bit, second-source register number, vector length, implied legacy prefix and opcode map. The register bits in the stream are stored complemented, and the decoder undoes that inversion. The opcode byte and addressing byte that follow are left to the next stage.

Outside 64-bit mode, 0xC4 and 0xC5 are also legacy pointer-load opcodes. The second byte decides which meaning applies. When the byte does not qualify, the decoder hands the first byte back as a legacy opcode and leaves the second byte unconsumed. The stream then offers that byte again as a fresh first byte. Any other first byte is handed back straight away.

The decoder raises an illegal fault when a disallowed legacy prefix came before the vector prefix. It raises an undefined fault when the three-byte form names an unknown opcode map.

Top module: `vexpfx_dec`

## Requirements
- R1: A first byte of 0xC5 starts the two-byte form and 0xC4 starts the three-byte form. Any other first byte gives a one-cycle `legacy` strobe with `legacy_byte` equal to that byte, in the cycle after it is accepted.
- R2: When `long_mode` is 0, a second byte whose bits [7:6] are not 11 is refused (`in_ready` low). In the next cycle `legacy` pulses with `legacy_byte` equal to the pending 0xC4/0xC5, and the refused byte is then accepted as a new first byte. When `long_mode` is 1, every second byte belongs to the prefix.
- R3: If any bit of `pfx_seen` (bit0 lock, bit1 operand-size, bit2 repeat, bit3 REX) is set when the second byte is accepted, `fault_ill` pulses in the next cycle and no `done` follows.
- R4: In the three-byte form, bits [4:0] of the second byte give the map: 1, 2 and 3 yield `opc_map` 1 (0F), 2 (0F 38) and 3 (0F 3A). Any other value gives a `fault_undef` pulse after the second byte, and no third byte is taken.
- R5: `ext_r`, `ext_x` and `ext_b` are the complements of second-byte bits 7, 6 and 5. In the two-byte form, `ext_x`, `ext_b` and `op_wide` read 0.
- R6: In the final prefix byte, `op_wide` is bit 7 (three-byte form only) and `src_reg` is the complement of bits [6:3]. `vec_len` is bit 2, and `impl_pfx` is bits [1:0] (0 none, 1 = 66, 2 = F3, 3 = F2).
- R7: The two-byte form always reports `opc_map` = 1.
- R8: When `long_mode` is 0, `ext_r`, `ext_x`, `ext_b`, `op_wide` and `src_reg[3]` read 0.
- R9: `done` pulses for exactly one cycle, in the cycle after the final prefix byte is accepted. At most one of `done`, `legacy`, `fault_ill`, `fault_undef` is high at a time. The decoded fields keep their values until the next `done`.
- R10: After reset, all strobes are low, all fields are 0 and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction byte is offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder takes the offered byte |
| long_mode | input | 1 | Processor is in 64-bit mode |
| pfx_seen | input | 4 | Legacy prefixes already seen: lock, operand-size, repeat, REX |
| done | output | 1 | Prefix fully decoded, fields valid |
| ext_r | output | 1 | Register-field extension bit |
| ext_x | output | 1 | Index extension bit |
| ext_b | output | 1 | Base extension bit |
| op_wide | output | 1 | Operand-width bit |
| src_reg | output | 4 | Second-source register number |
| vec_len | output | 1 | Vector length bit |
| impl_pfx | output | 2 | Implied legacy prefix code |
| opc_map | output | 2 | Opcode map code |
| legacy | output | 1 | First byte handed back as a legacy opcode |
| legacy_byte | output | 8 | Byte being handed back |
| fault_ill | output | 1 | Illegal prefix combination |
| fault_undef | output | 1 | Undefined opcode map |

## Verification
The hardest case to reach is the rewind. The decoder has to refuse a byte and then accept that same byte as a new first byte in the following cycle, so one offered byte yields two separate hand-backs. The stimulus gets there by clearing `long_mode`, sending 0xC4, and then holding a byte with bits [7:6] = 10 valid across two edges. It checks that `in_ready` is low on the first edge, that 0xC4 comes back, and that the held byte itself comes back on the next edge. The vector table also mixes in 32-bit-mode prefixes whose complemented fields would set the masked bits.

// File: rtl/vexpfx_dec.sv
module vexpfx_dec (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       in_ready,
  input  logic       long_mode,
  input  logic [3:0] pfx_seen,
  output logic       done,
  output logic       ext_r,
  output logic       ext_x,
  output logic       ext_b,
  output logic       op_wide,
  output logic [3:0] src_reg,
  output logic       vec_len,
  output logic [1:0] impl_pfx,
  output logic [1:0] opc_map,
  output logic       legacy,
  output logic [7:0] legacy_byte,
  output logic       fault_ill,
  output logic       fault_undef
);
  typedef enum logic [1:0] {S_IDLE, S_B2, S_B3} st_t;
  st_t st;
  logic [7:0] first_q, byte2_q;

  logic not_pfx, take, short_form, map_ok;
  logic [7:0] rb, lb;

  assign not_pfx    = (st == S_B2) && !long_mode && (in_byte[7:6] != 2'b11);
  assign in_ready   = !not_pfx;
  assign take       = in_valid && in_ready;
  assign short_form = (st == S_B2);
  assign rb         = (st == S_B3) ? byte2_q : in_byte;
  assign lb         = in_byte;
  assign map_ok     = (in_byte[4:2] == 3'b000) && (in_byte[1:0] != 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      first_q <= 8'h00;
      byte2_q <= 8'h00;
      done <= 1'b0;
      legacy <= 1'b0;
      legacy_byte <= 8'h00;
      fault_ill <= 1'b0;
      fault_undef <= 1'b0;
      ext_r <= 1'b0;
      ext_x <= 1'b0;
      ext_b <= 1'b0;
      op_wide <= 1'b0;
      src_reg <= 4'h0;
      vec_len <= 1'b0;
      impl_pfx <= 2'd0;
      opc_map <= 2'd0;
    end else begin
      done <= 1'b0;
      legacy <= 1'b0;
      fault_ill <= 1'b0;
      fault_undef <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          if (in_byte == 8'hC4 || in_byte == 8'hC5) begin
            first_q <= in_byte;
            st <= S_B2;
          end else begin
            legacy <= 1'b1;
            legacy_byte <= in_byte;
          end
        end
        S_B2: if (in_valid) begin
          st <= S_IDLE;
          if (not_pfx) begin
            legacy <= 1'b1;
            legacy_byte <= first_q;
          end else if (|pfx_seen) begin
            fault_ill <= 1'b1;
          end else if (first_q == 8'hC4) begin
            if (map_ok) begin
              byte2_q <= in_byte;
              st <= S_B3;
            end else begin
              fault_undef <= 1'b1;
            end
          end else begin
            done <= 1'b1;
          end
        end
        S_B3: if (take) begin
          st <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase

      if (take && ((st == S_B3) ||
                   (st == S_B2 && first_q == 8'hC5 && !(|pfx_seen)))) begin
        ext_r    <= long_mode & ~rb[7];
        ext_x    <= long_mode & ~short_form & ~rb[6];
        ext_b    <= long_mode & ~short_form & ~rb[5];
        op_wide  <= long_mode & ~short_form & lb[7];
        src_reg  <= {long_mode & ~lb[6], ~lb[5:3]};
        vec_len  <= lb[2];
        impl_pfx <= lb[1:0];
        opc_map  <= short_form ? 2'd1 : rb[1:0];
      end
    end
  end

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, legacy, fault_ill, fault_undef}));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_narrow_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(long_mode)) |-> (!ext_r && !ext_x && !ext_b && !op_wide && !src_reg[3]));

  a_r7_short_form_map: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(st) == S_B2) |-> (opc_map == 2'd1 && !ext_x && !ext_b && !op_wide));

  a_r2_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_B2 && in_valid && !long_mode && in_byte[7:6] != 2'b11)
      |=> (legacy && legacy_byte[7:1] == 7'b1100010));

  a_r3_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_B2 && take && |pfx_seen) |=> (fault_ill && !done));

  a_r4_map_defined: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (opc_map != 2'd0));
endmodule

// File: tb/test_vexpfx_dec.sv
`timescale 1ns/1ps
module test_vexpfx_dec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready;
  logic long_mode = 1'b1;
  logic [3:0] pfx_seen = 4'h0;
  logic done, ext_r, ext_x, ext_b, op_wide, vec_len, legacy, fault_ill, fault_undef;
  logic [3:0] src_reg;
  logic [1:0] impl_pfx, opc_map;
  logic [7:0] legacy_byte;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  vexpfx_dec i_vexpfx_dec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .long_mode(long_mode), .pfx_seen(pfx_seen),
    .done(done), .ext_r(ext_r), .ext_x(ext_x), .ext_b(ext_b),
    .op_wide(op_wide), .src_reg(src_reg), .vec_len(vec_len),
    .impl_pfx(impl_pfx), .opc_map(opc_map), .legacy(legacy),
    .legacy_byte(legacy_byte), .fault_ill(fault_ill), .fault_undef(fault_undef)
  );

  typedef struct packed {
    logic        lm;
    logic [3:0]  fl;
    logic [7:0]  b0;
    logic [7:0]  b1;
    logic [7:0]  b2;
    logic [1:0]  kind;
    logic [12:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    '{1'b1, 4'h0, 8'hC5, 8'h78, 8'h00, 2'd0, {1'b1,1'b0,1'b0,1'b0,4'd0, 1'b0,2'd0,2'd1}},
    '{1'b1, 4'h0, 8'hC5, 8'hC5, 8'h00, 2'd0, {1'b0,1'b0,1'b0,1'b0,4'd7, 1'b1,2'd1,2'd1}},
    '{1'b1, 4'h0, 8'hC4, 8'h62, 8'hF9, 2'd0, {1'b1,1'b0,1'b0,1'b1,4'd0, 1'b0,2'd1,2'd2}},
    '{1'b1, 4'h0, 8'hC4, 8'h03, 8'h06, 2'd0, {1'b1,1'b1,1'b1,1'b0,4'd15,1'b1,2'd2,2'd3}},
    '{1'b0, 4'h0, 8'hC4, 8'hE1, 8'h83, 2'd0, {1'b0,1'b0,1'b0,1'b0,4'd7, 1'b0,2'd3,2'd1}},
    '{1'b0, 4'h0, 8'hC5, 8'hC7, 8'h00, 2'd0, {1'b0,1'b0,1'b0,1'b0,4'd7, 1'b1,2'd3,2'd1}},
    '{1'b1, 4'h1, 8'hC5, 8'hF8, 8'h00, 2'd1, 13'd0},
    '{1'b1, 4'h4, 8'hC4, 8'h61, 8'h00, 2'd1, 13'd0},
    '{1'b1, 4'h0, 8'hC4, 8'hE4, 8'h00, 2'd2, 13'd0},
    '{1'b1, 4'h0, 8'hC4, 8'hE0, 8'h00, 2'd2, 13'd0},
    '{1'b0, 4'h2, 8'hC5, 8'hC0, 8'h00, 2'd1, 13'd0},
    '{1'b1, 4'h0, 8'hC5, 8'h38, 8'h00, 2'd0, {1'b1,1'b0,1'b0,1'b0,4'd8, 1'b0,2'd0,2'd1}},
    '{1'b0, 4'h0, 8'hC4, 8'hC2, 8'h44, 2'd0, {1'b0,1'b0,1'b0,1'b0,4'd7, 1'b1,2'd0,2'd2}}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  function automatic logic [12:0] fields();
    return {ext_r, ext_x, ext_b, op_wide, src_reg, vec_len, impl_pfx, opc_map};
  endfunction

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 strobes after reset", {28'd0, done, legacy, fault_ill, fault_undef}, 32'd0);
    chk("R10 fields after reset", {19'd0, fields()}, 32'd0);
    chk("R10 ready after reset", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [12:0] held;
      @(negedge clk);
      long_mode = VT[i].lm;
      pfx_seen = VT[i].fl;
      send(VT[i].b0);
      chk("R1 no strobe after first byte", {28'd0, done, legacy, fault_ill, fault_undef}, 32'd0);
      send(VT[i].b1);
      if (VT[i].kind == 2'd1) begin
        chk("R3 illegal fault", {28'd0, done, legacy, fault_ill, fault_undef}, 32'h2);
      end else if (VT[i].kind == 2'd2) begin
        chk("R4 undefined map fault", {28'd0, done, legacy, fault_ill, fault_undef}, 32'h1);
      end else begin
        if (VT[i].b0 == 8'hC4) begin
          chk("R4 no strobe after map byte", {28'd0, done, legacy, fault_ill, fault_undef}, 32'd0);
          send(VT[i].b2);
        end
        chk("R9 done strobe", {28'd0, done, legacy, fault_ill, fault_undef}, 32'h8);
        chk("R5 R6 R7 R8 decoded fields", {19'd0, fields()}, {19'd0, VT[i].exp});
        held = fields();
        @(posedge clk);
        #1;
        chk("R9 done lasts one cycle", {31'd0, done}, 32'd0);
        chk("R9 fields held", {19'd0, fields()}, {19'd0, held});
      end
    end

    long_mode = 1'b1;
    pfx_seen = 4'h0;
    send(8'h90);
    chk("R1 non-prefix handed back", {23'd0, legacy, legacy_byte}, {23'd0, 1'b1, 8'h90});

    long_mode = 1'b1;
    send(8'hC5);
    send(8'h05);
    chk("R2 long mode keeps prefix", {30'd0, done, legacy}, 32'h2);

    @(negedge clk);
    long_mode = 1'b0;
    send(8'hC4);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte = 8'h8B;
    #1;
    chk("R2 second byte refused", {31'd0, in_ready}, 32'd0);
    @(posedge clk);
    #1;
    chk("R2 first byte handed back", {22'd0, done, legacy, legacy_byte}, {22'd0, 1'b0, 1'b1, 8'hC4});
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    chk("R2 refused byte re-read as first", {23'd0, legacy, legacy_byte}, {23'd0, 1'b1, 8'h8B});

    repeat (2) @(posedge clk);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule